// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block watches the boundary between the decode and execute stages of an in-order five-stage pipeline. When the instruction sitting in execute is a load, and the instruction sitting in decode names the load's destination register as one of its two sources, the result cannot be forwarded in time. The block then holds the program counter and the fetch/decode register for one clock cycle and turns the instruction entering execute into a no-op by clearing its control bits. One cycle later the load has moved to memory access. The dependent instruction can then take the loaded value through the normal forwarding paths.

For verification the top level wraps the detector in a small pipeline front end. This front end has a program counter that steps by one, a fetch/decode register holding the fetched instruction's fields, and a decode/execute control register. The instruction memory sits outside the block. It supplies the fields of the instruction at `pc_o` on the `in_*` inputs. Each instruction carries a tag so that its passage through execute can be observed.

Top module: `lu_stall_top`

## Requirements
- R1: A stall is raised when the decode/execute memory-read flag is 1, its source-B field (the load destination) is nonzero, and that field equals the fetch/decode source-A or source-B field. During a stall, `pc_we_o` and `ifid_we_o` are 0 and `bubble_o` is 1 in the same cycle.
- R2: On the clock edge that ends a stall cycle, the decode/execute register captures memory-read, memory-write and register-write all equal to 0, so the instruction then in execute is a no-op.
- R3: During a stall cycle, the program counter and the fetch/decode register keep their contents across the clock edge.
- R4: Each load-use pair produces exactly one stall cycle. This holds even when the dependent instruction is itself a load that writes the same register.
- R5: No stall occurs when the instruction in execute is not a load, even if its register fields match.
- R6: A load whose destination field is register 0 never causes a stall.
- R7: Outside a stall, the program counter increases by 1 every cycle. The fetch/decode register loads the fetched instruction, and its tag and control bits reach execute unchanged one cycle later.
- R8: While `rst_n` is low at a clock edge, the program counter goes to 0 and both pipeline registers are cleared to a no-op with all-zero fields.
- R9: A load followed by a dependent instruction two slots later, with an independent instruction between them, produces no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_tag | input | 8 | Tag of the instruction at `pc_o` (0 means no instruction) |
| in_rs | input | 5 | Source-A register field of the fetched instruction |
| in_rt | input | 5 | Source-B register field (destination of a load) |
| in_mem_rd | input | 1 | Fetched instruction is a load |
| in_mem_wr | input | 1 | Fetched instruction is a store |
| in_reg_wr | input | 1 | Fetched instruction writes a register |
| pc_o | output | 8 | Current program counter |
| pc_we_o | output | 1 | Program counter write enable (0 during a stall) |
| ifid_we_o | output | 1 | Fetch/decode register write enable (0 during a stall) |
| bubble_o | output | 1 | Control-zero request for the instruction entering execute |
| ex_tag_o | output | 8 | Tag held in the decode/execute register |
| ex_rt_o | output | 5 | Source-B field held in the decode/execute register |
| ex_mem_rd_o | output | 1 | Memory-read control in execute |
| ex_mem_wr_o | output | 1 | Memory-write control in execute |
| ex_reg_wr_o | output | 1 | Register-write control in execute |

## Verification
The stall signals (`bubble_o`, `pc_we_o`, `ifid_we_o`) are combinational on the two pipeline registers. They are therefore due in the cycle a load reaches execute while its consumer sits in decode, which is two edges after the load was fetched. The cleared controls and the held program counter are due one edge after a stall cycle, and the dependent instruction enters execute one edge after that. The bench samples every output at the falling edge. It checks the stall flags in the sample where they rise, and checks the no-op contents and the held counter in the very next sample. It also compares the order of non-no-op tags in execute against the program and counts the stall cycles in each scenario.

// File: rtl/lu_pkg.sv
// Shared widths and the instruction record passed between the front-end stages.
// Assumes register fields index a 32-entry register file with register 0 hard-wired.
package lu_pkg;
    parameter int REG_W = 5;
    parameter int TAG_W = 8;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic             mem_rd;
        logic             mem_wr;
        logic             reg_wr;
    } instr_t;
endpackage

// File: rtl/lu_hazard_detect.sv
// Load-use hazard detector. Purely combinational on the decode/execute and
// fetch/decode register contents. Assumes a load names its destination in the
// source-B field and that register 0 never carries a real dependence.
module lu_hazard_detect
    import lu_pkg::*;
(
    input  logic             ex_mem_rd,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             ctrl_zero
);
    logic dst_live;
    logic src_hit;

    // Compare the load destination with both decode sources and form the stall.
    always_comb begin
        dst_live  = (ex_rt != '0);
        src_hit   = (ex_rt == id_rs) || (ex_rt == id_rt);
        ctrl_zero = ex_mem_rd && dst_live && src_hit;
        pc_we     = !ctrl_zero;
        ifid_we   = !ctrl_zero;
    end
endmodule

// File: rtl/lu_front_stage.sv
// Program counter and fetch/decode register. Both advance together when enabled.
// Assumes one instruction per address, so the counter steps by one.
module lu_front_stage
    import lu_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    input  logic            ifid_we,
    input  instr_t          fetch_in,
    output logic [PC_W-1:0] pc_q,
    output instr_t          id_q
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

    // Program counter: reset to zero, step when the write enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= pc_q + PC_STEP;
    end

    // Fetch/decode register: capture the fetched fields unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)       id_q <= '0;
        else if (ifid_we) id_q <= fetch_in;
    end

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> pc_q == $past(pc_q));
    assert_ifid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ifid_we |=> id_q == $past(id_q));
    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> pc_q == $past(pc_q) + PC_STEP);
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0) && (id_q == '0));
endmodule

// File: rtl/lu_ex_stage.sv
// Decode/execute register. Passes the decoded record through, or substitutes a
// no-op (all three memory/register controls cleared) when asked to zero controls.
// Assumes the tag and register fields may pass unchanged inside a no-op.
module lu_ex_stage
    import lu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ctrl_zero,
    input  instr_t id_in,
    output instr_t ex_q
);
    instr_t ex_d;

    // Build the next execute record, clearing its controls for a bubble.
    always_comb begin
        ex_d = id_in;
        if (ctrl_zero) begin
            ex_d.mem_rd = 1'b0;
            ex_d.mem_wr = 1'b0;
            ex_d.reg_wr = 1'b0;
        end
    end

    // Register the execute record every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ex_q <= '0;
        else        ex_q <= ex_d;
    end

    assert_bubble_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> !ex_q.mem_rd && !ex_q.mem_wr && !ex_q.reg_wr);
    assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_zero |=> ex_q == $past(id_in));
endmodule

// File: rtl/lu_stall_top.sv
// Load-use stall unit with its surrounding front-end model: program counter,
// fetch/decode register, hazard detector and decode/execute control register.
// Assumes the caller presents the fields of the instruction at pc_o each cycle.
module lu_stall_top
    import lu_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [REG_W-1:0] in_rs,
    input  logic [REG_W-1:0] in_rt,
    input  logic             in_mem_rd,
    input  logic             in_mem_wr,
    input  logic             in_reg_wr,
    output logic [PC_W-1:0]  pc_o,
    output logic             pc_we_o,
    output logic             ifid_we_o,
    output logic             bubble_o,
    output logic [TAG_W-1:0] ex_tag_o,
    output logic [REG_W-1:0] ex_rt_o,
    output logic             ex_mem_rd_o,
    output logic             ex_mem_wr_o,
    output logic             ex_reg_wr_o
);
    instr_t fetch_w;
    instr_t id_q;
    instr_t ex_q;
    logic   pc_we;
    logic   ifid_we;
    logic   ctrl_zero;

    // Pack the fetched fields into one record.
    always_comb begin
        fetch_w.tag    = in_tag;
        fetch_w.rs     = in_rs;
        fetch_w.rt     = in_rt;
        fetch_w.mem_rd = in_mem_rd;
        fetch_w.mem_wr = in_mem_wr;
        fetch_w.reg_wr = in_reg_wr;
    end

    lu_front_stage #(.PC_W(PC_W)) front_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_we    (pc_we),
        .ifid_we  (ifid_we),
        .fetch_in (fetch_w),
        .pc_q     (pc_o),
        .id_q     (id_q)
    );

    lu_hazard_detect hazard_i (
        .ex_mem_rd (ex_q.mem_rd),
        .ex_rt     (ex_q.rt),
        .id_rs     (id_q.rs),
        .id_rt     (id_q.rt),
        .pc_we     (pc_we),
        .ifid_we   (ifid_we),
        .ctrl_zero (ctrl_zero)
    );

    lu_ex_stage ex_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_zero (ctrl_zero),
        .id_in     (id_q),
        .ex_q      (ex_q)
    );

    // Drive the observable outputs.
    always_comb begin
        pc_we_o     = pc_we;
        ifid_we_o   = ifid_we;
        bubble_o    = ctrl_zero;
        ex_tag_o    = ex_q.tag;
        ex_rt_o     = ex_q.rt;
        ex_mem_rd_o = ex_q.mem_rd;
        ex_mem_wr_o = ex_q.mem_wr;
        ex_reg_wr_o = ex_q.reg_wr;
    end

    assert_single_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> !ctrl_zero);
    assert_no_stall_nonload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_q.mem_rd |-> pc_we && ifid_we && !ctrl_zero);
    assert_no_stall_r0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_q.rt == '0) |-> !ctrl_zero);
    assert_stall_enables_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |-> !pc_we && !ifid_we);
endmodule

// File: tb/lu_stall_top_tb_top.sv
`timescale 1ns/1ps
module lu_stall_top_tb_top;
    import lu_pkg::*;

    localparam int PC_W  = 8;
    localparam int NPROG = 8;
    localparam int NRUN  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [REG_W-1:0] in_rs = '0;
    logic [REG_W-1:0] in_rt = '0;
    logic             in_mem_rd = 1'b0;
    logic             in_mem_wr = 1'b0;
    logic             in_reg_wr = 1'b0;
    logic [PC_W-1:0]  pc_o;
    logic             pc_we_o, ifid_we_o, bubble_o;
    logic [TAG_W-1:0] ex_tag_o;
    logic [REG_W-1:0] ex_rt_o;
    logic             ex_mem_rd_o, ex_mem_wr_o, ex_reg_wr_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [REG_W-1:0] p_rs [NPROG];
    logic [REG_W-1:0] p_rt [NPROG];
    logic             p_mr [NPROG];
    logic             p_mw [NPROG];
    logic             p_rw [NPROG];
    int               p_len;

    always #2 clk = ~clk;

    lu_stall_top #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_tag(in_tag), .in_rs(in_rs), .in_rt(in_rt),
        .in_mem_rd(in_mem_rd), .in_mem_wr(in_mem_wr), .in_reg_wr(in_reg_wr),
        .pc_o(pc_o), .pc_we_o(pc_we_o), .ifid_we_o(ifid_we_o), .bubble_o(bubble_o),
        .ex_tag_o(ex_tag_o), .ex_rt_o(ex_rt_o),
        .ex_mem_rd_o(ex_mem_rd_o), .ex_mem_wr_o(ex_mem_wr_o), .ex_reg_wr_o(ex_reg_wr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_prog();
        for (int i = 0; i < NPROG; i++) begin
            p_rs[i] = '0; p_rt[i] = '0; p_mr[i] = 1'b0; p_mw[i] = 1'b0; p_rw[i] = 1'b0;
        end
        p_len = 0;
    endtask

    // Append one instruction; its tag is its position plus one.
    task automatic add_ins(input int rs, input int rt, input bit mr, input bit mw, input bit rw);
        p_rs[p_len] = REG_W'(rs); p_rt[p_len] = REG_W'(rt);
        p_mr[p_len] = mr; p_mw[p_len] = mw; p_rw[p_len] = rw;
        p_len++;
    endtask

    // Present the instruction at the current PC (no-op past the program end).
    task automatic drive_fetch();
        int a;
        a = int'(pc_o);
        if (a < p_len) begin
            in_tag = TAG_W'(a + 1); in_rs = p_rs[a]; in_rt = p_rt[a];
            in_mem_rd = p_mr[a]; in_mem_wr = p_mw[a]; in_reg_wr = p_rw[a];
        end else begin
            in_tag = '0; in_rs = '0; in_rt = '0;
            in_mem_rd = 1'b0; in_mem_wr = 1'b0; in_reg_wr = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_tag = '0; in_rs = '0; in_rt = '0;
        in_mem_rd = 1'b0; in_mem_wr = 1'b0; in_reg_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Scenario: reset leaves a cleared pipeline with the counter at zero.
    task automatic t_reset();
        clr_prog();
        do_reset();
        chk(pc_o == '0, "R8 pc after reset", int'(pc_o), 0);
        chk(!ex_mem_rd_o && !ex_mem_wr_o && !ex_reg_wr_o && ex_tag_o == '0,
            "R8 execute cleared", int'({ex_mem_rd_o, ex_mem_wr_o, ex_reg_wr_o}), 0);
        chk(!bubble_o && pc_we_o && ifid_we_o, "R8 no stall after reset",
            int'(bubble_o), 0);
    endtask

    // Run the loaded program; check stall count, bubble contents, held PC and
    // the order and controls of real instructions passing through execute.
    task automatic run_prog(input string req, input int exp_stalls);
        int  stalls;
        int  next_tag;
        bit  prev_bub;
        logic [PC_W-1:0] prev_pc;
        bit  order_ok;
        bit  ctrl_ok;
        stalls = 0; next_tag = 1; prev_bub = 1'b0; prev_pc = '0;
        order_ok = 1'b1; ctrl_ok = 1'b1;
        do_reset();
        drive_fetch();
        for (int c = 0; c < NRUN; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (prev_bub) begin
                chk(!ex_mem_rd_o && !ex_mem_wr_o && !ex_reg_wr_o, {req, " R2 bubble controls"},
                    int'({ex_mem_rd_o, ex_mem_wr_o, ex_reg_wr_o}), 0);
                chk(pc_o == prev_pc, {req, " R3 pc held"}, int'(pc_o), int'(prev_pc));
            end
            if (bubble_o) begin
                stalls++;
                chk(!pc_we_o && !ifid_we_o, {req, " R1 enables low in stall"},
                    int'({pc_we_o, ifid_we_o}), 0);
            end
            if (ex_tag_o != '0 && (ex_mem_rd_o || ex_mem_wr_o || ex_reg_wr_o)) begin
                if (int'(ex_tag_o) != next_tag) order_ok = 1'b0;
                else begin
                    if (ex_mem_rd_o != p_mr[next_tag-1] || ex_mem_wr_o != p_mw[next_tag-1] ||
                        ex_reg_wr_o != p_rw[next_tag-1]) ctrl_ok = 1'b0;
                    next_tag++;
                end
            end
            prev_bub = bubble_o;
            prev_pc  = pc_o;
            drive_fetch();
        end
        chk(stalls == exp_stalls, {req, " stall count"}, stalls, exp_stalls);
        chk(order_ok && next_tag == p_len + 1, {req, " R7 execute order"}, next_tag - 1, p_len);
        chk(ctrl_ok, {req, " R7 controls pass unchanged"}, int'(ctrl_ok), 1);
    endtask

    task automatic t_use_rs();
        clr_prog();
        add_ins(1, 2, 1, 0, 1);   // load into r2
        add_ins(2, 5, 0, 0, 1);   // uses r2 as source A
        add_ins(4, 2, 0, 0, 1);   // uses r2 again, no stall
        add_ins(4, 2, 0, 0, 1);
        run_prog("R4 load then source-A use", 1);
    endtask

    task automatic t_use_rt();
        clr_prog();
        add_ins(1, 6, 1, 0, 1);   // load into r6
        add_ins(3, 6, 0, 0, 1);   // uses r6 as source B
        add_ins(7, 8, 0, 0, 1);
        run_prog("R1 load then source-B use", 1);
    endtask

    task automatic t_load_load();
        clr_prog();
        add_ins(1, 3, 1, 0, 1);   // load into r3
        add_ins(7, 3, 1, 0, 1);   // load that also targets r3
        add_ins(9, 10, 0, 0, 1);
        run_prog("R4 load after load single stall", 1);
    endtask

    task automatic t_independent();
        clr_prog();
        add_ins(1, 2, 1, 0, 1);
        add_ins(3, 4, 0, 0, 1);
        add_ins(5, 6, 0, 1, 0);   // store passes through
        run_prog("R7 independent stream", 0);
    endtask

    task automatic t_nonload();
        clr_prog();
        add_ins(1, 2, 0, 0, 1);   // arithmetic writing r2
        add_ins(2, 2, 0, 0, 1);
        run_prog("R5 non-load producer", 0);
    endtask

    task automatic t_reg0();
        clr_prog();
        add_ins(1, 0, 1, 0, 1);   // load into r0
        add_ins(0, 0, 0, 0, 1);
        run_prog("R6 load to register 0", 0);
    endtask

    task automatic t_gap();
        clr_prog();
        add_ins(1, 2, 1, 0, 1);
        add_ins(3, 4, 0, 0, 1);
        add_ins(2, 2, 0, 0, 1);
        run_prog("R9 use two slots later", 0);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_use_rs();
        t_use_rt();
        t_load_load();
        t_independent();
        t_nonload();
        t_reg0();
        t_gap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule